// File: doc/BRIEF.md
# Operand Size Prefix Resolver

This decoder stage watches the bytes of one instruction as they arrive, first the prefixes and then the primary opcode, which may be preceded by a single 0Fh escape byte. It works out three things: the effective operand size (16, 32 or 64 bits), the effective address size, and whether the opcode is illegal in 64-bit mode. Bytes arrive one at a time under a valid/ready handshake. A mode input selects 64-bit operation or legacy operation. A built-in attribute table marks the opcodes that default to 64 bits, the opcodes whose size is fixed, and the opcodes that are illegal in 64-bit mode.

Prefix bytes only update the internal prefix state. When the opcode byte is accepted, the stage registers the result and presents it for exactly one cycle on the result outputs. It then clears the prefix state so the next instruction starts clean. In 64-bit mode, bytes 40h to 4Fh act as a register-extension prefix, and bit 3 of that byte is the wide-operand flag W. The prefix counts only when it sits directly before the opcode or its escape byte.

Top module: `opsize_resolver`

## Requirements
- R1: While `rst` is high, `in_ready` and `res_valid` are 0. After reset, `in_ready` is 1 and the prefix state is empty.
- R2: `res_valid` is high for exactly one cycle, in the cycle after an opcode byte is accepted. Prefix bytes and idle cycles do not raise it, and idle cycles between prefix bytes keep the collected prefixes.
- R3: Size encodings on `res_opsize` and `res_addrsize` are 0 = 16 bits, 1 = 32 bits, 2 = 64 bits. In 64-bit mode with no prefix, an ordinary opcode gives operand size 1 and address size 2.
- R4: A 66h prefix makes an ordinary opcode 16-bit in either mode. With LEGACY_DEF32 = 0, the legacy default is 16 bits and 66h selects 32 bits.
- R5: In 64-bit mode, a byte 40h..4Fh with bit 3 set selects operand size 64. This holds even when 66h is also present.
- R6: The register-extension prefix is dropped if any legacy prefix (66h, 67h, F0h, F2h, F3h, 26h, 2Eh, 36h, 3Eh, 64h, 65h) follows it. A legacy prefix that comes before it has no such effect.
- R7: Default-64 opcodes (50h..5Fh, C3h, C8h, C9h, E8h, E9h, EBh) give operand size 64 in 64-bit mode without W. With 66h they give 16. They never give 32.
- R8: Fixed-size opcodes (F4h, F5h, 0Fh 06h, 0Fh A2h) always give operand size 32 under the default parameters, ignoring 66h and W, and raise no error.
- R9: `res_invalid` is 1 for opcodes 27h, 2Fh and CEh in 64-bit mode, and 0 for them in legacy mode.
- R10: Address size is 64 in 64-bit mode and 32 with 67h. In legacy mode (LEGACY_DEF32 = 1) it is 32, and 16 with 67h.
- R11: In legacy mode, 40h..4Fh are opcodes and produce a result at once with operand size 32. Default-64 opcodes give 32 there.
- R12: After 0Fh, the next byte is always the opcode and is looked up in the secondary map. For example, 0Fh 27h is not invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Stage accepts a byte |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| res_valid | output | 1 | One-cycle result strobe |
| res_opsize | output | 2 | Effective operand size code |
| res_addrsize | output | 2 | Effective address size code |
| res_invalid | output | 1 | Opcode is illegal in 64-bit mode |

## Verification
The bench builds the stage with LEGACY_DEF32 = 1, the protected-mode legacy default. This brings within reach every 64-bit mode rule and the 32/16 toggles of legacy mode. The vector table pairs each prefix ordering of interest (66h and W in both orders, W before a legacy prefix, W after one) with ordinary, default-64, fixed and illegal opcodes in both modes. Directed tests cover the strobe timing, idle gaps inside a prefix run, and a reset that lands mid-instruction.

// File: rtl/opsz_pkg.sv
package opsz_pkg;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ32 = 2'd1,
        SZ64 = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        BK_LEGACY,
        BK_REX,
        BK_ESC,
        BK_OPC
    } bkind_e;

    typedef struct packed {
        logic d64;
        logic fixed;
        logic bad_lm;
    } attr_t;

    typedef struct packed {
        logic p66;
        logic p67;
        logic rex_live;
        logic rex_w;
        logic esc;
    } pfx_t;

    typedef struct packed {
        size_e op;
        size_e adr;
        logic  inv;
    } res_t;

    localparam logic [7:0] OSZ_BYTE = 8'h66;
    localparam logic [7:0] ASZ_BYTE = 8'h67;
    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [3:0] REX_HI   = 4'h4;

    function automatic logic is_legacy(input logic [7:0] b);
        case (b)
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bkind_e classify(input logic [7:0] b, input logic lm, input logic esc);
        if (esc)                        return BK_OPC;
        else if (is_legacy(b))          return BK_LEGACY;
        else if (lm && b[7:4] == REX_HI) return BK_REX;
        else if (b == ESC_BYTE)         return BK_ESC;
        else                            return BK_OPC;
    endfunction

    function automatic attr_t lookup(input logic [7:0] b, input logic esc);
        attr_t a;
        a = '0;
        if (esc) begin
            a.fixed = (b == 8'h06) || (b == 8'hA2);
        end else begin
            a.d64    = (b[7:4] == 4'h5) || (b == 8'hC3) || (b == 8'hC8) ||
                       (b == 8'hC9) || (b == 8'hE8) || (b == 8'hE9) || (b == 8'hEB);
            a.fixed  = (b == 8'hF4) || (b == 8'hF5);
            a.bad_lm = (b == 8'h27) || (b == 8'h2F) || (b == 8'hCE);
        end
        return a;
    endfunction

endpackage

// File: rtl/opsz_prefix_tracker.sv
module opsz_prefix_tracker
    import opsz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [7:0] byte_i,
    input  logic       lm,
    output bkind_e     kind,
    output pfx_t       pfx_q
);

    assign kind = classify(byte_i, lm, pfx_q.esc);

    always_ff @(posedge clk) begin
        if (rst) begin
            pfx_q <= '0;
        end else if (fire) begin
            case (kind)
                BK_LEGACY: begin
                    if (byte_i == OSZ_BYTE) pfx_q.p66 <= 1'b1;
                    if (byte_i == ASZ_BYTE) pfx_q.p67 <= 1'b1;
                    pfx_q.rex_live <= 1'b0;
                    pfx_q.rex_w    <= 1'b0;
                end
                BK_REX: begin
                    pfx_q.rex_live <= 1'b1;
                    pfx_q.rex_w    <= byte_i[3];
                end
                BK_ESC:  pfx_q.esc <= 1'b1;
                default: pfx_q <= '0;
            endcase
        end
    end

    // R5: an extension byte in 64-bit mode arms the prefix
    assert_rex_arm_R5: assert property (@(posedge clk) disable iff (rst)
        fire && lm && byte_i[7:4] == REX_HI && !pfx_q.esc |=> pfx_q.rex_live);

    // R6: a legacy prefix after the extension byte drops it
    assert_rex_drop_R6: assert property (@(posedge clk) disable iff (rst)
        fire && !pfx_q.esc && is_legacy(byte_i) |=> !pfx_q.rex_live);

endmodule

// File: rtl/opsz_size_calc.sv
module opsz_size_calc
    import opsz_pkg::*;
#(
    parameter bit LEGACY_DEF32 = 1'b1
) (
    input  pfx_t       pfx,
    input  logic [7:0] opc,
    input  logic       lm,
    output res_t       res
);

    localparam size_e LEG_BASE = LEGACY_DEF32 ? SZ32 : SZ16;
    localparam size_e LEG_ALT  = LEGACY_DEF32 ? SZ16 : SZ32;

    attr_t attr;
    assign attr = lookup(opc, pfx.esc);

    always_comb begin
        res = '{op: SZ32, adr: SZ64, inv: 1'b0};
        if (lm) begin
            res.adr = pfx.p67 ? SZ32 : SZ64;
            res.inv = attr.bad_lm;
            if (attr.fixed)                      res.op = SZ32;
            else if (pfx.rex_live && pfx.rex_w)  res.op = SZ64;
            else if (pfx.p66)                    res.op = SZ16;
            else if (attr.d64)                   res.op = SZ64;
            else                                 res.op = SZ32;
        end else begin
            res.adr = pfx.p67 ? LEG_ALT : LEG_BASE;
            res.op  = (pfx.p66 && !attr.fixed) ? LEG_ALT : LEG_BASE;
        end
    end

endmodule

// File: rtl/opsize_resolver.sv
module opsize_resolver
    import opsz_pkg::*;
#(
    parameter bit LEGACY_DEF32 = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       long_mode,
    output logic       res_valid,
    output logic [1:0] res_opsize,
    output logic [1:0] res_addrsize,
    output logic       res_invalid
);

    logic   fire;
    logic   opc_fire;
    bkind_e kind;
    pfx_t   pfx;
    res_t   nxt, res_q;
    logic   vld_q;

    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;
    assign opc_fire = fire && (kind == BK_OPC);

    opsz_prefix_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .byte_i (in_byte),
        .lm     (long_mode),
        .kind   (kind),
        .pfx_q  (pfx)
    );

    opsz_size_calc #(.LEGACY_DEF32(LEGACY_DEF32)) u_calc (
        .pfx (pfx),
        .opc (in_byte),
        .lm  (long_mode),
        .res (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= opc_fire;
            if (opc_fire) res_q <= nxt;
        end
    end

    assign res_valid    = vld_q;
    assign res_opsize   = res_q.op;
    assign res_addrsize = res_q.adr;
    assign res_invalid  = res_q.inv;

    // R2: strobe follows an accepted opcode by one cycle, never otherwise
    assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        opc_fire |=> res_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !opc_fire |=> !res_valid);

    // R9 / R11: legacy-mode results are never 64-bit and never illegal
    assert_legacy_clean_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid && !$past(long_mode) |-> !res_invalid && res_opsize != SZ64 && res_addrsize != SZ64);

    // R10: 64-bit mode addressing is never 16-bit
    assert_lm_addr_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid && $past(long_mode) |-> res_addrsize != SZ16);

endmodule

// File: tb/sim_opsize_resolver.sv
module sim_opsize_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    // entry: {lm[40], cnt[39:37], bytes[36:5] first byte high, op[4:3], adr[2:1], inv[0]}
    localparam logic [40:0] VT [0:NV-1] = '{
        {1'b1, 3'd1, 32'h01000000, 2'd1, 2'd2, 1'b0}, // R3 plain
        {1'b1, 3'd2, 32'h66010000, 2'd0, 2'd2, 1'b0}, // R4 66h
        {1'b1, 3'd2, 32'h48010000, 2'd2, 2'd2, 1'b0}, // R5 W
        {1'b1, 3'd3, 32'h66480100, 2'd2, 2'd2, 1'b0}, // R5 W beats 66h
        {1'b1, 3'd3, 32'h48660100, 2'd0, 2'd2, 1'b0}, // R6 W then 66h: dropped
        {1'b1, 3'd2, 32'h67010000, 2'd1, 2'd1, 1'b0}, // R10 67h
        {1'b1, 3'd1, 32'h50000000, 2'd2, 2'd2, 1'b0}, // R7 default-64
        {1'b1, 3'd2, 32'h66500000, 2'd0, 2'd2, 1'b0}, // R7 66h -> 16
        {1'b1, 3'd2, 32'h40500000, 2'd2, 2'd2, 1'b0}, // R7 no W
        {1'b1, 3'd3, 32'h6648F500, 2'd1, 2'd2, 1'b0}, // R8 fixed
        {1'b1, 3'd3, 32'h480FA200, 2'd1, 2'd2, 1'b0}, // R8 fixed, escaped
        {1'b1, 3'd1, 32'h27000000, 2'd1, 2'd2, 1'b1}, // R9 27h
        {1'b1, 3'd1, 32'hCE000000, 2'd1, 2'd2, 1'b1}, // R9 CEh
        {1'b1, 3'd1, 32'h2F000000, 2'd1, 2'd2, 1'b1}, // R9 2Fh
        {1'b0, 3'd1, 32'h27000000, 2'd1, 2'd1, 1'b0}, // R9 legacy 27h
        {1'b0, 3'd1, 32'h48000000, 2'd1, 2'd1, 1'b0}, // R11 48h is opcode
        {1'b0, 3'd2, 32'h66010000, 2'd0, 2'd1, 1'b0}, // R4 legacy 66h
        {1'b0, 3'd2, 32'h67010000, 2'd1, 2'd0, 1'b0}, // R10 legacy 67h
        {1'b0, 3'd1, 32'h50000000, 2'd1, 2'd1, 1'b0}, // R11 legacy default-64
        {1'b1, 3'd2, 32'h0F270000, 2'd1, 2'd2, 1'b0}, // R12 escaped 27h
        {1'b1, 3'd3, 32'hF3480100, 2'd2, 2'd2, 1'b0}, // R6 legacy before W
        {1'b1, 3'd2, 32'h4F010000, 2'd2, 2'd2, 1'b0}  // R5 4Fh
    };
    localparam int REQ [0:NV-1] = '{3,4,5,5,6,10,7,7,7,8,8,9,9,9,9,11,4,10,11,12,6,5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_ready;
    logic long_mode = 1'b1;
    logic res_valid;
    logic [1:0] res_opsize, res_addrsize;
    logic res_invalid;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opsize_resolver u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .long_mode(long_mode), .res_valid(res_valid),
        .res_opsize(res_opsize), .res_addrsize(res_addrsize), .res_invalid(res_invalid)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic finish_instr();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [5:0] outs();
        return {res_valid, res_opsize, res_addrsize, res_invalid};
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset ready/valid", {4'd0, in_ready, res_valid}, 6'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {4'd0, in_ready, res_valid}, 6'b000010);

        // table walk
        for (int i = 0; i < NV; i++) begin
            long_mode = VT[i][40];
            for (int k = 0; k < int'(VT[i][39:37]); k++)
                send_byte(VT[i][36 - 8*k -: 8]);
            finish_instr();
            if (outs() !== {1'b1, VT[i][4:0]}) begin
                checks++; fails++;
                $display("FAIL R%0d vector %0d: actual %b expected %b", REQ[i], i, outs(), {1'b1, VT[i][4:0]});
            end else checks++;
        end

        // R2: no strobe on a prefix, gaps keep prefixes, one-cycle pulse
        long_mode = 1'b1;
        send_byte(8'h66);
        finish_instr();
        check("R2 no strobe after prefix", {5'd0, res_valid}, 6'd0);
        repeat (2) @(negedge clk);
        send_byte(8'h48);
        finish_instr();
        check("R2 no strobe after extension byte", {5'd0, res_valid}, 6'd0);
        @(negedge clk);
        send_byte(8'h01);
        finish_instr();
        check("R2 gap keeps prefixes (R5)", outs(), {1'b1, 2'd2, 2'd2, 1'b0});
        @(negedge clk);
        check("R2 strobe lasts one cycle", {5'd0, res_valid}, 6'd0);

        // R2: back-to-back opcodes give back-to-back strobes, state cleared
        send_byte(8'h66);
        send_byte(8'h01);
        send_byte(8'h01);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second opcode starts clean", outs(), {1'b1, 2'd1, 2'd2, 1'b0});

        // R1: reset mid-instruction clears collected prefixes
        send_byte(8'h66);
        send_byte(8'h67);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 valid low in reset", {4'd0, in_ready, res_valid}, 6'd0);
        rst = 1'b0;
        send_byte(8'h01);
        finish_instr();
        check("R1 prefixes cleared by reset", outs(), {1'b1, 2'd1, 2'd2, 1'b0});

        // R12: 0Fh then 66h is an escaped opcode, not a prefix
        send_byte(8'h0F);
        send_byte(8'h66);
        finish_instr();
        check("R12 byte after escape is opcode", outs(), {1'b1, 2'd1, 2'd2, 1'b0});

        // R8: fixed size with 66h in legacy mode
        long_mode = 1'b0;
        send_byte(8'h66);
        send_byte(8'hF4);
        finish_instr();
        check("R8 fixed ignores 66h in legacy", outs(), {1'b1, 2'd1, 2'd1, 1'b0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule